// File: doc/BRIEF.md
# Configurable Registered Command/Address Buffer

This block sits between a memory controller and the DRAM devices of a registered memory module. It captures command and address bits on the rising clock edge and drives them to the devices. A static mode input picks between two layouts. In the single-copy layout, every data input has its own output register. In the duplicated layout, a narrower set of channels is registered, and each captured bit drives two identical outputs, copy A and copy B. These feed two separate device loads.

In the duplicated layout, a second static input chooses which group of data inputs feeds the narrow channel set: the lower group or the upper group. Three control channels are always registered whatever the chip-select state: clock-enable, termination-enable and chip-select. The data outputs can be frozen. This happens when the chip-select input and a gating-enable input are both high at a clock edge. An asynchronous active-low reset clears every register and forces every output low. Reset overrides the freeze.

The layout inputs are sampled only on clock edges while reset is asserted. During operation they are therefore ignored.

Top module: `cmd_reg_buffer`

## Requirements
- R1: In the single-copy layout, with the freeze condition false at a rising edge, `q_a` equals the `d_in` value sampled at that edge.
- R2: In the duplicated layout, `q_b` always equals `q_a[DUP_W-1:0]`, and `q_a[DATA_W-1:DUP_W]` stays 0. The control B copies (`cke_b`, `odt_b`, `cs_b`) equal their A copies.
- R3: In the duplicated layout, channel k captures `d_in[k]` when `alt_map` was 0 at the last configuration sample. It captures `d_in[DATA_W-DUP_W+k]` when `alt_map` was 1.
- R4: While `rst_n` is low, every output is 0. This holds immediately on assertion, without a clock edge, and also while the freeze condition is true.
- R5: When `cs_in` and `csr_in` are both 1 at a rising edge, `q_a` and `q_b` keep their previous values.
- R6: `cke_a`, `odt_a` and `cs_a` equal `cke_in`, `odt_in` and `cs_in` sampled at the previous rising edge outside reset, regardless of the freeze condition.
- R7: In the single-copy layout, `q_b`, `cke_b`, `odt_b` and `cs_b` are 0.
- R8: `dup_mode` and `alt_map` are sampled only at rising edges while `rst_n` is low. A change while `rst_n` is high has no effect on any output.
- R9: With `csr_in` at 0, `cs_in` = 1 does not freeze the data: `q_a` updates at every edge.
- R10: After `rst_n` rises with all data and control inputs at 0 and the clock running, every output remains 0 at every sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; layout inputs sampled while low |
| dup_mode | input | 1 | 0 = single-copy layout, 1 = duplicated layout |
| alt_map | input | 1 | Duplicated-layout source group: 0 = lower inputs, 1 = upper inputs |
| d_in | input | DATA_W | Command/address data inputs |
| cke_in | input | 1 | Clock-enable channel input |
| odt_in | input | 1 | Termination-enable channel input |
| cs_in | input | 1 | Chip-select channel input; also one of the two freeze terms |
| csr_in | input | 1 | Freeze enable; ties the freeze off when 0 |
| q_a | output | DATA_W | Registered data, copy A |
| q_b | output | DUP_W | Registered data, copy B (duplicated layout only) |
| cke_a | output | 1 | Registered clock-enable, copy A |
| cke_b | output | 1 | Registered clock-enable, copy B |
| odt_a | output | 1 | Registered termination-enable, copy A |
| odt_b | output | 1 | Registered termination-enable, copy B |
| cs_a | output | 1 | Registered chip-select, copy A |
| cs_b | output | 1 | Registered chip-select, copy B |

## Verification
The freeze and the reset can land in the same cycle. The freeze and a control-channel update can also land in the same cycle. In both cases one path must win and the other must still behave correctly. The bench holds `cs_in` and `csr_in` high and then drops `rst_n` between edges, then reads the outputs before any further edge; all of them must already be zero. The bench also changes `cke_in` and `cs_in` while the data is frozen, and judges that the control outputs follow while `q_a` and `q_b` hold.

// File: rtl/cmd_reg_buffer_pkg.sv
package cmd_reg_buffer_pkg;
   typedef struct packed {
      logic dup;
      logic alt;
   } layout_t;
endpackage

// File: rtl/crb_layout_cap.sv
module crb_layout_cap
   import cmd_reg_buffer_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    dup_mode,
   input  logic    alt_map,
   output layout_t layout
);
   // layout inputs are sampled only while reset holds the block
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         layout.dup <= dup_mode;
         layout.alt <= alt_map;
      end
   end
endmodule

// File: rtl/crb_data_bank.sv
module crb_data_bank
   import cmd_reg_buffer_pkg::*;
#(
   parameter int DATA_W = 22,
   parameter int DUP_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  layout_t           layout,
   input  logic              hold,
   input  logic [DATA_W-1:0] d_in,
   output logic [DATA_W-1:0] q
);
   localparam int OFS = DATA_W - DUP_W;

   logic [DATA_W-1:0] nxt;

   generate
      for (genvar k = 0; k < DATA_W; k++) begin : g_ch
         if (k < DUP_W) begin : g_shared
            always_comb begin
               if (layout.dup && layout.alt) nxt[k] = d_in[OFS+k];
               else                          nxt[k] = d_in[k];
            end
         end else begin : g_single
            always_comb nxt[k] = layout.dup ? 1'b0 : d_in[k];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (!hold) q <= nxt;
   end
endmodule

// File: rtl/crb_ctl_bank.sv
module crb_ctl_bank #(
   parameter int CTL_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CTL_W-1:0] c_in,
   output logic [CTL_W-1:0] c_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) c_q <= '0;
      else        c_q <= c_in;
   end
endmodule

// File: rtl/cmd_reg_buffer.sv
module cmd_reg_buffer
   import cmd_reg_buffer_pkg::*;
#(
   parameter int DATA_W = 22,
   parameter int DUP_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dup_mode,
   input  logic              alt_map,
   input  logic [DATA_W-1:0] d_in,
   input  logic              cke_in,
   input  logic              odt_in,
   input  logic              cs_in,
   input  logic              csr_in,
   output logic [DATA_W-1:0] q_a,
   output logic [DUP_W-1:0]  q_b,
   output logic              cke_a,
   output logic              cke_b,
   output logic              odt_a,
   output logic              odt_b,
   output logic              cs_a,
   output logic              cs_b
);
   localparam int CTL_W = 3;

   generate
      if (DUP_W < 1 || 2*DUP_W > DATA_W) begin : g_bad_width
         $error("cmd_reg_buffer: DUP_W must satisfy 1 <= DUP_W <= DATA_W/2");
      end
   endgenerate

   layout_t           layout;
   logic              hold;
   logic [DATA_W-1:0] dq;
   logic [CTL_W-1:0]  cq;

   assign hold = cs_in & csr_in;

   crb_layout_cap u_layout (
      .clk(clk), .rst_n(rst_n), .dup_mode(dup_mode), .alt_map(alt_map),
      .layout(layout)
   );

   crb_data_bank #(.DATA_W(DATA_W), .DUP_W(DUP_W)) u_data (
      .clk(clk), .rst_n(rst_n), .layout(layout), .hold(hold),
      .d_in(d_in), .q(dq)
   );

   crb_ctl_bank #(.CTL_W(CTL_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .c_in({cs_in, odt_in, cke_in}), .c_q(cq)
   );

   assign q_a   = dq;
   assign q_b   = layout.dup ? dq[DUP_W-1:0] : '0;
   assign cke_a = cq[0];
   assign odt_a = cq[1];
   assign cs_a  = cq[2];
   assign cke_b = layout.dup & cq[0];
   assign odt_b = layout.dup & cq[1];
   assign cs_b  = layout.dup & cq[2];
endmodule

// File: rtl/cmd_reg_buffer_chk.sv
module cmd_reg_buffer_chk #(
   parameter int DATA_W = 22,
   parameter int DUP_W  = 11
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_dup,
   input logic              cfg_alt,
   input logic [DATA_W-1:0] d_in,
   input logic              cke_in,
   input logic              cs_in,
   input logic              csr_in,
   input logic [DATA_W-1:0] q_a,
   input logic [DUP_W-1:0]  q_b,
   input logic              cke_a,
   input logic              cke_b,
   input logic              odt_a,
   input logic              odt_b,
   input logic              cs_a,
   input logic              cs_b
);
   localparam int OFS = DATA_W - DUP_W;

   // R1
   plain_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_dup && !(cs_in && csr_in)) |=> (q_a == $past(d_in)));

   // R2
   dup_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_dup |-> (q_b == q_a[DUP_W-1:0] && q_a[DATA_W-1:DUP_W] == '0
                   && cke_b == cke_a && cs_b == cs_a && odt_b == odt_a));

   // R3
   dup_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_dup && !(cs_in && csr_in)) |=>
      (q_a[DUP_W-1:0] == (cfg_alt ? $past(d_in[OFS +: DUP_W]) : $past(d_in[DUP_W-1:0]))));

   // R4
   reset_low_chk: assert property (@(posedge clk)
      !rst_n |-> (q_a == '0 && q_b == '0 && !cke_a && !cke_b && !odt_a && !odt_b && !cs_a && !cs_b));

   // R5
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_in && csr_in) |=> ($stable(q_a) && $stable(q_b)));

   // R6
   ctl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (cke_a == $past(cke_in) && cs_a == $past(cs_in)));

   // R7
   single_b_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_dup |-> (q_b == '0 && !cke_b && !odt_b && !cs_b));

   // R8
   layout_static_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ($stable(cfg_dup) && $stable(cfg_alt)));
endmodule

bind cmd_reg_buffer cmd_reg_buffer_chk #(.DATA_W(DATA_W), .DUP_W(DUP_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_dup(layout.dup), .cfg_alt(layout.alt),
   .d_in(d_in), .cke_in(cke_in), .cs_in(cs_in), .csr_in(csr_in),
   .q_a(q_a), .q_b(q_b), .cke_a(cke_a), .cke_b(cke_b),
   .odt_a(odt_a), .odt_b(odt_b), .cs_a(cs_a), .cs_b(cs_b)
);

// File: tb/tb_cmd_reg_buffer.sv
module tb_cmd_reg_buffer;
   localparam int PERIOD = 10;
   localparam int DATA_W = 22;
   localparam int DUP_W  = 11;
   localparam int OFS    = DATA_W - DUP_W;

   logic              clk = 1'b0;
   logic              rst_n, dup_mode, alt_map;
   logic [DATA_W-1:0] d_in;
   logic              cke_in, odt_in, cs_in, csr_in;
   logic [DATA_W-1:0] q_a;
   logic [DUP_W-1:0]  q_b;
   logic              cke_a, cke_b, odt_a, odt_b, cs_a, cs_b;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   always #(PERIOD/2) clk = ~clk;

   cmd_reg_buffer #(.DATA_W(DATA_W), .DUP_W(DUP_W)) dut (
      .clk(clk), .rst_n(rst_n), .dup_mode(dup_mode), .alt_map(alt_map),
      .d_in(d_in), .cke_in(cke_in), .odt_in(odt_in), .cs_in(cs_in), .csr_in(csr_in),
      .q_a(q_a), .q_b(q_b), .cke_a(cke_a), .cke_b(cke_b),
      .odt_a(odt_a), .odt_b(odt_b), .cs_a(cs_a), .cs_b(cs_b)
   );

   function automatic logic [63:0] all_out();
      return 64'({q_a, q_b, cke_a, cke_b, odt_a, odt_b, cs_a, cs_b});
   endfunction

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // inputs change and outputs are read 2 time units after a rising edge
   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic zero_inputs();
      d_in = '0; cke_in = 0; odt_in = 0; cs_in = 0; csr_in = 0;
   endtask

   task automatic do_reset(input logic dup, input logic alt);
      rst_n = 0; dup_mode = dup; alt_map = alt;
      #1;
      chk("R4 outputs low on reset assertion", all_out(), 64'd0);
      zero_inputs();
      tick(); tick();
      chk("R4 outputs low during reset", all_out(), 64'd0);
      rst_n = 1;
   endtask

   task automatic t_plain();
      d_in = 22'h15A5A5; cke_in = 1; odt_in = 1; cs_in = 0; csr_in = 0;
      tick();
      chk("R1 single-copy capture", 64'(q_a), 64'(22'h15A5A5));
      chk("R7 q_b low in single-copy", 64'(q_b), 64'd0);
      chk("R7 control B copies low", 64'({cke_b, odt_b, cs_b}), 64'd0);
      chk("R6 cke/odt registered", 64'({cke_a, odt_a}), 64'b11);
      d_in = 22'h0F0F0F; cke_in = 0;
      tick();
      chk("R1 single-copy second pattern", 64'(q_a), 64'(22'h0F0F0F));
      chk("R6 cke follows", 64'(cke_a), 64'd0);
   endtask

   task automatic t_dup(input logic alt);
      logic [DUP_W-1:0] exp;
      do_reset(1, alt);
      d_in = 22'h2B4C7D; cke_in = 1; cs_in = 1; csr_in = 0;
      exp = alt ? d_in[OFS +: DUP_W] : d_in[DUP_W-1:0];
      tick();
      chk("R3 duplicated source group", 64'(q_a[DUP_W-1:0]), 64'(exp));
      chk("R2 unused A outputs low", 64'(q_a[DATA_W-1:DUP_W]), 64'd0);
      chk("R2 copy B equals copy A", 64'(q_b), 64'(exp));
      chk("R2 control B copies", 64'({cke_b, cs_b}), 64'b11);
   endtask

   task automatic t_freeze();
      do_reset(0, 0);
      d_in = 22'h111111; cs_in = 0; csr_in = 1; cke_in = 0;
      tick();
      chk("R1 pre-freeze load", 64'(q_a), 64'(22'h111111));
      d_in = 22'h2AAAAA; cs_in = 1; cke_in = 1;
      tick();
      chk("R5 data frozen", 64'(q_a), 64'(22'h111111));
      chk("R6 cs and cke update during freeze", 64'({cs_a, cke_a}), 64'b11);
      d_in = 22'h355555; cke_in = 0;
      tick();
      chk("R5 data still frozen", 64'(q_a), 64'(22'h111111));
      chk("R6 cke drops during freeze", 64'(cke_a), 64'd0);
      csr_in = 0;
      tick();
      chk("R9 csr low disables freeze", 64'(q_a), 64'(22'h355555));
      chk("R9 cs registered as data", 64'(cs_a), 64'd1);
      // freeze active, then reset between edges
      cs_in = 1; csr_in = 1; cke_in = 1;
      tick();
      rst_n = 0;
      #1;
      chk("R4 reset overrides freeze", all_out(), 64'd0);
      tick();
      chk("R4 still low at edge under freeze", all_out(), 64'd0);
      zero_inputs();
      tick();
      rst_n = 1;
   endtask

   task automatic t_static();
      do_reset(0, 0);
      dup_mode = 1; alt_map = 1;
      d_in = 22'h3ABCDE;
      tick();
      chk("R8 layout change ignored, full width", 64'(q_a), 64'(22'h3ABCDE));
      chk("R8 layout change ignored, B low", 64'(q_b), 64'd0);
   endtask

   task automatic t_glitch();
      do_reset(1, 0);
      for (int i = 0; i < 4; i++) begin
         chk("R10 outputs low after reset release", all_out(), 64'd0);
         #4;
         chk("R10 outputs low mid-cycle", all_out(), 64'd0);
         tick();
      end
   endtask

   initial begin
      rst_n = 0; dup_mode = 0; alt_map = 0;
      zero_inputs();
      repeat (3) @(posedge clk);
      #2;
      chk("R4 reset state", all_out(), 64'd0);
      rst_n = 1;
      t_plain();
      t_dup(0);
      t_dup(1);
      t_freeze();
      t_static();
      t_glitch();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(PERIOD * 5000);
      if (!done) begin
         done = 1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule